// File: doc/BRIEF.md
# DMA Line-Splitting Request Sequencer

The sequencer takes one DMA transfer at a time from a requester: a start byte address, a byte length, a direction and a flag saying whether a completion response is wanted. It cuts the transfer into memory transactions that never cross a cache-line boundary and sends them one at a time toward a memory controller. Only the first transaction may start inside a line. Each later one starts on a line boundary and covers a full line, or whatever is left of the transfer.

For a store, the block reads the requester's write bytes through a window port. It names the transfer offset it needs, and the requester returns a line's worth of bytes from that offset. The block shifts those bytes to their lane in the line and marks them with byte enables. For a load, each returned line is shifted down so that the first wanted byte sits in lane 0. The result is presented to the requester's buffer with the transfer offset and the byte count.

While a transfer is active, further requests are refused. A refusal is remembered, and a one-cycle retry pulse is sent when the active transfer ends. A drain request is answered at once when the block is idle. If the block is busy, the drain request is held and answered when the transfer finishes.

The state machine has three states:
- IDLE: no transfer is active.
- ISSUE: a transaction is presented and is waiting for the memory side to take it.
- WAIT: a transaction has been taken and the block is waiting for its completion.

It has four transitions:
- start (IDLE to ISSUE): a request with nonzero length is accepted.
- sent (ISSUE to WAIT): the memory side takes the transaction.
- next (WAIT to ISSUE): a completion arrives and bytes remain.
- finish (WAIT to IDLE): a completion arrives and no bytes remain.

A zero-length request is accepted in IDLE, and the block stays in IDLE.

Top module: `dma_line_seq`

## Requirements
- R1: Only one transfer is active at a time. `req_ready` is high exactly in IDLE. It is low from the edge that accepts a nonzero-length request until the edge that completes its final transaction.
- R2: A request presented while `req_ready` is low is refused and leaves the active transfer unchanged. If any refusal happened during a transfer, `retry_o` is high for exactly one cycle, the cycle right after the final completion. `req_ready` is already high in that cycle.
- R3: The first transaction uses the start address unchanged. Its length is the request length if the in-line offset (start address modulo LINE_BYTES) plus the length is at most LINE_BYTES. Otherwise its length is LINE_BYTES minus the offset.
- R4: Each later transaction starts at the start address plus the bytes completed so far. That address is line aligned, and the length is the smaller of the remaining bytes and LINE_BYTES.
- R5: `mem_req_store` is 1 for a write transfer and 0 for a read. For a store, transfer byte k goes to line lane (lane offset + k - completed), where byte k is lane (k - completed) of `wr_buf_data` and `wr_buf_off` equals the completed count. The lane offset is the in-line offset for the first transaction and 0 for later ones. `mem_req_be` has exactly the bits of those lanes set.
- R6: A transaction stays presented, with stable address and length, until `mem_req_ready` is high. No new transaction is presented until the previous one has completed (`mem_done_valid` in WAIT).
- R7: During a read completion, `rd_buf_we` is high. `rd_buf_off` is the completed count, `rd_buf_len` is the length of the transaction, and lane i of `rd_buf_data` is lane (lane offset + i) of `mem_done_data`. During a write completion, `rd_buf_we` stays low.
- R8: `rsp_valid` pulses for one cycle, two clock edges after the edge that completes the final transaction, and only when the request asked for a response.
- R9: `drained` is high exactly when no transfer is active. A drain request made in IDLE is answered by a one-cycle `drain_done` on the next cycle. A drain request made while busy is answered in the cycle right after the final completion, and not before.
- R10: A zero-length request is accepted, issues no transaction, and gives `rsp_valid` two edges after its acceptance when asked.
- R11: After reset, the block is idle. `req_ready` and `drained` are 1; `mem_req_valid`, `rsp_valid`, `retry_o`, `drain_done` and `rd_buf_we` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Requester presents a transfer |
| req_ready | output | 1 | Transfer accepted when high with req_valid |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Transfer length in bytes |
| req_write | input | 1 | 1 = write to memory, 0 = read |
| req_need_rsp | input | 1 | Completion response wanted |
| wr_buf_off | output | LEN_W | Transfer offset of the write bytes needed |
| wr_buf_data | input | 8*LINE_BYTES | Write bytes from wr_buf_off onward, byte 0 in the low lane |
| rd_buf_we | output | 1 | Read bytes are valid for the requester buffer |
| rd_buf_off | output | LEN_W | Transfer offset of rd_buf_data lane 0 |
| rd_buf_len | output | LEN_W | Number of valid read bytes |
| rd_buf_data | output | 8*LINE_BYTES | Read bytes aligned to lane 0 |
| rsp_valid | output | 1 | One-cycle completion response |
| retry_o | output | 1 | One-cycle wake-up after a refusal |
| mem_req_valid | output | 1 | Transaction presented |
| mem_req_ready | input | 1 | Memory side takes the transaction |
| mem_req_addr | output | ADDR_W | Transaction byte address |
| mem_req_len | output | LEN_W | Transaction byte count |
| mem_req_store | output | 1 | 1 = store, 0 = load |
| mem_req_data | output | 8*LINE_BYTES | Store bytes placed in line lanes |
| mem_req_be | output | LINE_BYTES | Byte enables of the store lanes |
| mem_done_valid | input | 1 | Completion: data return or acknowledgment |
| mem_done_data | input | 8*LINE_BYTES | Returned line for a load |
| drain_req | input | 1 | Request to be told when idle |
| drained | output | 1 | No transfer active |
| drain_done | output | 1 | One-cycle answer to a drain request |

## Verification
The assertions take some things for granted about the inputs. They assume the memory side raises `mem_done_valid` only in WAIT, exactly once per taken transaction. They assume `req_len` fits LEN_W, and they assume lines are aligned to LINE_BYTES. The bench behaves as such a memory. It asserts completions only after it has handed over a transaction, and it adds random acceptance stalls and completion delays. It draws random addresses and lengths (including zero) within the width limits, and it adds directed cases for exact line fits, one-byte overruns, last-lane starts, refusals and drain requests made both while idle and while busy.

// File: rtl/dls_pkg.sv
package dls_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } dls_state_e;
endpackage

// File: rtl/dls_chunk_calc.sv
// Address, length and lane offset of the next line-bounded transaction.
module dls_chunk_calc #(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 12,
    parameter int LINE_BYTES = 16
) (
    input  logic [ADDR_W-1:0]             start_addr,
    input  logic [LEN_W-1:0]              total_len,
    input  logic [LEN_W-1:0]              done_bytes,
    input  logic                          first,
    output logic [ADDR_W-1:0]             chunk_addr,
    output logic [LEN_W-1:0]              chunk_len,
    output logic [$clog2(LINE_BYTES)-1:0] lane_off
);
    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam logic [LEN_W:0] LINE_L = (LEN_W+1)'(LINE_BYTES);

    logic [OFF_W-1:0] start_off;
    logic [LEN_W:0]   head_end;
    logic [LEN_W:0]   remain;

    always_comb begin
        start_off = start_addr[OFF_W-1:0];
        head_end  = (LEN_W+1)'(start_off) + {1'b0, total_len};
        remain    = {1'b0, total_len} - {1'b0, done_bytes};
        if (first) begin
            chunk_addr = start_addr;
            lane_off   = start_off;
            chunk_len  = (head_end <= LINE_L) ? total_len
                                              : LEN_W'(LINE_L - (LEN_W+1)'(start_off));
        end else begin
            chunk_addr = start_addr + ADDR_W'(done_bytes);
            lane_off   = '0;
            chunk_len  = (remain < LINE_L) ? remain[LEN_W-1:0] : LEN_W'(LINE_BYTES);
        end
    end
endmodule

// File: rtl/dls_lane_map.sv
// Moves bytes between transfer order and line lanes.
module dls_lane_map #(
    parameter int LEN_W      = 12,
    parameter int LINE_BYTES = 16
) (
    input  logic [$clog2(LINE_BYTES)-1:0] lane_off,
    input  logic [LEN_W-1:0]              chunk_len,
    input  logic [LINE_BYTES*8-1:0]       src_bytes,
    input  logic [LINE_BYTES*8-1:0]       line_bytes,
    output logic [LINE_BYTES*8-1:0]       placed,
    output logic [LINE_BYTES-1:0]         placed_be,
    output logic [LINE_BYTES*8-1:0]       extracted
);
    localparam int RUN_W = LINE_BYTES + 1;

    logic [RUN_W-1:0] run;

    always_comb begin
        run       = (RUN_W'(1) << chunk_len) - RUN_W'(1);
        placed_be = run[LINE_BYTES-1:0] << lane_off;
        placed    = src_bytes << {lane_off, 3'b000};
        extracted = line_bytes >> {lane_off, 3'b000};
    end
endmodule

// File: rtl/dma_line_seq.sv
module dma_line_seq
    import dls_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 12,
    parameter int LINE_BYTES = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [LEN_W-1:0]        req_len,
    input  logic                    req_write,
    input  logic                    req_need_rsp,
    output logic [LEN_W-1:0]        wr_buf_off,
    input  logic [LINE_BYTES*8-1:0] wr_buf_data,
    output logic                    rd_buf_we,
    output logic [LEN_W-1:0]        rd_buf_off,
    output logic [LEN_W-1:0]        rd_buf_len,
    output logic [LINE_BYTES*8-1:0] rd_buf_data,
    output logic                    rsp_valid,
    output logic                    retry_o,
    output logic                    mem_req_valid,
    input  logic                    mem_req_ready,
    output logic [ADDR_W-1:0]       mem_req_addr,
    output logic [LEN_W-1:0]        mem_req_len,
    output logic                    mem_req_store,
    output logic [LINE_BYTES*8-1:0] mem_req_data,
    output logic [LINE_BYTES-1:0]   mem_req_be,
    input  logic                    mem_done_valid,
    input  logic [LINE_BYTES*8-1:0] mem_done_data,
    input  logic                    drain_req,
    output logic                    drained,
    output logic                    drain_done
);
    localparam int OFF_W = $clog2(LINE_BYTES);

    dls_state_e state_q, state_d;

    logic [ADDR_W-1:0] start_q;
    logic [LEN_W-1:0]  len_q, done_q, iss_q;
    logic              wr_q, need_q, first_q;
    logic              fin_q, fin_need_q, rsp_q, retry_q;
    logic              retry_pend_q, drain_pend_q, drain_done_q;

    logic [ADDR_W-1:0] c_addr;
    logic [LEN_W-1:0]  c_len;
    logic [OFF_W-1:0]  c_off;

    logic accept, refuse, zero_acc, issue_fire, chunk_done, last_done, idle;

    dls_chunk_calc #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .LINE_BYTES(LINE_BYTES)) calc_i (
        .start_addr (start_q),
        .total_len  (len_q),
        .done_bytes (done_q),
        .first      (first_q),
        .chunk_addr (c_addr),
        .chunk_len  (c_len),
        .lane_off   (c_off)
    );

    dls_lane_map #(.LEN_W(LEN_W), .LINE_BYTES(LINE_BYTES)) lanes_i (
        .lane_off   (c_off),
        .chunk_len  (c_len),
        .src_bytes  (wr_buf_data),
        .line_bytes (mem_done_data),
        .placed     (mem_req_data),
        .placed_be  (mem_req_be),
        .extracted  (rd_buf_data)
    );

    always_comb begin
        idle       = (state_q == ST_IDLE);
        accept     = req_valid && idle;
        refuse     = req_valid && !idle;
        zero_acc   = accept && (req_len == '0);
        issue_fire = (state_q == ST_ISSUE) && mem_req_ready;
        chunk_done = (state_q == ST_WAIT) && mem_done_valid;
        last_done  = chunk_done && (iss_q == len_q);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept && !zero_acc) state_d = ST_ISSUE;
            ST_ISSUE: if (mem_req_ready)       state_d = ST_WAIT;
            ST_WAIT:  if (mem_done_valid)      state_d = last_done ? ST_IDLE : ST_ISSUE;
            default:                           state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transfer bookkeeping and completion pipeline
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= '0; len_q <= '0; done_q <= '0; iss_q <= '0;
            wr_q <= 1'b0; need_q <= 1'b0; first_q <= 1'b0;
            fin_q <= 1'b0; fin_need_q <= 1'b0; rsp_q <= 1'b0; retry_q <= 1'b0;
            retry_pend_q <= 1'b0; drain_pend_q <= 1'b0; drain_done_q <= 1'b0;
        end else begin
            if (accept) begin
                start_q <= req_addr;
                len_q   <= req_len;
                wr_q    <= req_write;
                need_q  <= req_need_rsp;
                done_q  <= '0;
                iss_q   <= '0;
                first_q <= 1'b1;
            end
            if (issue_fire) iss_q <= done_q + c_len;
            if (chunk_done) begin
                done_q  <= iss_q;
                first_q <= 1'b0;
            end
            fin_q        <= last_done || zero_acc;
            fin_need_q   <= last_done ? need_q : req_need_rsp;
            rsp_q        <= fin_q && fin_need_q;
            retry_q      <= last_done && (retry_pend_q || refuse);
            retry_pend_q <= last_done ? 1'b0 : (retry_pend_q || refuse);
            drain_done_q <= (drain_req || drain_pend_q) && (idle || last_done);
            drain_pend_q <= (drain_req || drain_pend_q) && !(idle || last_done);
        end
    end

    // outputs
    always_comb begin
        req_ready     = idle;
        drained       = idle;
        mem_req_valid = (state_q == ST_ISSUE);
        mem_req_addr  = c_addr;
        mem_req_len   = c_len;
        mem_req_store = wr_q;
        wr_buf_off    = done_q;
        rd_buf_we     = chunk_done && !wr_q;
        rd_buf_off    = done_q;
        rd_buf_len    = iss_q - done_q;
        rsp_valid     = rsp_q;
        retry_o       = retry_q;
        drain_done    = drain_done_q;
    end

    // R6
    issue_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_len));
    // R4
    line_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !first_q |-> mem_req_addr[OFF_W-1:0] == '0);
    // R3
    chunk_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_len != '0) &&
        ((LEN_W+1)'(c_off) + (LEN_W+1)'(mem_req_len) <= (LEN_W+1)'(LINE_BYTES)));
    // R1
    single_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready);
    // R2
    retry_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        retry_o |-> req_ready && !$past(req_ready));
    // R7
    rd_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_buf_we |-> (rd_buf_len != '0) && (rd_buf_len <= LEN_W'(LINE_BYTES)));
endmodule

// File: tb/dma_line_seq_tb_top.sv
`timescale 1ns/1ps
module dma_line_seq_tb_top;
    localparam int AW = 32, LW = 12, LB = 16, DW = LB*8;

    logic clk = 0, rst_n = 0;
    logic req_valid = 0, req_ready, req_write = 0, req_need_rsp = 0;
    logic [AW-1:0] req_addr = '0;
    logic [LW-1:0] req_len = '0;
    logic [LW-1:0] wr_buf_off, rd_buf_off, rd_buf_len, mem_req_len;
    logic [DW-1:0] wr_buf_data, rd_buf_data, mem_req_data, mem_done_data = '0;
    logic rd_buf_we, rsp_valid, retry_o, mem_req_valid, mem_req_ready = 0, mem_req_store;
    logic [AW-1:0] mem_req_addr;
    logic [LB-1:0] mem_req_be;
    logic mem_done_valid = 0, drain_req = 0, drained, drain_done;

    int errors = 0, checks = 0;

    always #4 clk = ~clk;

    dma_line_seq #(.ADDR_W(AW), .LEN_W(LW), .LINE_BYTES(LB)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .req_write(req_write),
        .req_need_rsp(req_need_rsp), .wr_buf_off(wr_buf_off), .wr_buf_data(wr_buf_data),
        .rd_buf_we(rd_buf_we), .rd_buf_off(rd_buf_off), .rd_buf_len(rd_buf_len),
        .rd_buf_data(rd_buf_data), .rsp_valid(rsp_valid), .retry_o(retry_o),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_req_len(mem_req_len),
        .mem_req_store(mem_req_store), .mem_req_data(mem_req_data),
        .mem_req_be(mem_req_be), .mem_done_valid(mem_done_valid),
        .mem_done_data(mem_done_data), .drain_req(drain_req), .drained(drained),
        .drain_done(drain_done)
    );

    function automatic logic [7:0] gbyte(int k);   // requester write pattern
        return 8'((k * 13 + 5) ^ 8'hA5);
    endfunction
    function automatic logic [7:0] fbyte(int a);   // memory content pattern
        return 8'(a * 7 + (a >> 8) + 3);
    endfunction
    function automatic int exp_clen(int st, int tot, int dn, bit first);
        int off = st % LB;
        if (first) return (off + tot <= LB) ? tot : LB - off;
        return (tot - dn < LB) ? tot - dn : LB;
    endfunction

    always_comb
        for (int j = 0; j < LB; j++) wr_buf_data[j*8 +: 8] = gbyte(int'(wr_buf_off) + j);

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic run_xfer(int addr, int len, bit wr, bit need, bit refuse, bit drn);
        int dn = 0, n, clen, eaddr, lo, bad_lane;
        bit first = 1, injected = 0;
        logic [LB-1:0] ebe;
        req_addr = AW'(addr); req_len = LW'(len); req_write = wr; req_need_rsp = need;
        req_valid = 1;
        #1 chk(req_ready == 1, "R1", "ready when idle", int'(req_ready), 1);
        @(negedge clk); req_valid = 0;
        if (len == 0) begin
            // R10: no transaction, response two edges after acceptance
            chk(mem_req_valid == 0 && rsp_valid == 0, "R10", "zero-length first cycle",
                int'(mem_req_valid) + int'(rsp_valid), 0);
            @(negedge clk);
            chk(rsp_valid == need && mem_req_valid == 0, "R10", "zero-length response",
                int'(rsp_valid), int'(need));
            return;
        end
        chk(req_ready == 0 && drained == 0, "R1", "busy after accept", int'(req_ready), 0);
        while (dn < len) begin
            n = 0;
            while (!mem_req_valid && n < 20) begin @(negedge clk); n++; end
            clen  = exp_clen(addr, len, dn, first);
            eaddr = first ? addr : addr + dn;
            lo    = first ? addr % LB : 0;
            chk(mem_req_addr == AW'(eaddr), first ? "R3" : "R4", "chunk addr", int'(mem_req_addr), eaddr);
            chk(mem_req_len == LW'(clen), first ? "R3" : "R4", "chunk len", int'(mem_req_len), clen);
            chk(mem_req_store == wr, "R5", "store tag", int'(mem_req_store), int'(wr));
            if (wr) begin
                ebe = '0; bad_lane = -1;
                for (int i = 0; i < clen; i++) begin
                    ebe[lo + i] = 1'b1;
                    if (mem_req_data[(lo+i)*8 +: 8] != gbyte(dn + i) && bad_lane < 0) bad_lane = lo + i;
                end
                chk(mem_req_be == ebe, "R5", "byte enables", int'(mem_req_be), int'(ebe));
                chk(bad_lane < 0, "R5", "store lane data", bad_lane, -1);
                chk(wr_buf_off == LW'(dn), "R5", "write window offset", int'(wr_buf_off), dn);
            end
            repeat ($urandom % 3) begin
                @(negedge clk);
                chk(mem_req_valid && mem_req_addr == AW'(eaddr) && mem_req_len == LW'(clen),
                    "R6", "held while stalled", int'(mem_req_addr), eaddr);
            end
            mem_req_ready = 1;
            @(negedge clk); mem_req_ready = 0;
            if (!injected && (refuse || drn)) begin
                injected = 1;
                if (refuse) begin
                    req_valid = 1; req_addr = 32'hFFF0; req_len = 5;
                    #1 chk(req_ready == 0, "R2", "refused while busy", int'(req_ready), 0);
                end
                if (drn) drain_req = 1;
                @(negedge clk); req_valid = 0; drain_req = 0;
            end
            repeat ($urandom % 3) begin
                chk(mem_req_valid == 0, "R6", "no issue before completion", int'(mem_req_valid), 0);
                if (drn) chk(drain_done == 0, "R9", "no drain answer while busy", int'(drain_done), 0);
                @(negedge clk);
            end
            for (int j = 0; j < LB; j++)
                mem_done_data[j*8 +: 8] = fbyte((eaddr - (eaddr % LB)) + j);
            mem_done_valid = 1;
            #1;
            if (!wr) begin
                bad_lane = -1;
                for (int i = 0; i < clen; i++)
                    if (rd_buf_data[i*8 +: 8] != fbyte(eaddr + i) && bad_lane < 0) bad_lane = i;
                chk(rd_buf_we && rd_buf_off == LW'(dn) && rd_buf_len == LW'(clen), "R7",
                    "read return window", int'(rd_buf_len), clen);
                chk(bad_lane < 0, "R7", "read lane data", bad_lane, -1);
            end else chk(rd_buf_we == 0, "R7", "no read write-enable on store", int'(rd_buf_we), 0);
            @(negedge clk); mem_done_valid = 0;
            dn += clen; first = 0;
        end
        chk(req_ready == 1 && rsp_valid == 0, "R8", "idle, response not yet", int'(rsp_valid), 0);
        chk(retry_o == refuse, "R2", "retry pulse after end", int'(retry_o), int'(refuse));
        chk(drain_done == drn, "R9", "drain answer at end", int'(drain_done), int'(drn));
        @(negedge clk);
        chk(rsp_valid == need, "R8", "response pulse", int'(rsp_valid), int'(need));
        chk(retry_o == 0 && drain_done == 0, "R2", "pulses one cycle", int'(retry_o), 0);
        @(negedge clk);
        chk(rsp_valid == 0, "R8", "response one cycle", int'(rsp_valid), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11 reset state
        chk(req_ready && drained && !mem_req_valid && !rsp_valid && !retry_o && !drain_done && !rd_buf_we,
            "R11", "reset state", int'(mem_req_valid), 0);
        run_xfer(32'h200, 0, 0, 1, 0, 0);       // R10
        run_xfer(32'h205, 0, 1, 0, 0, 0);       // R10
        run_xfer(32'h100, 16, 0, 1, 0, 0);      // aligned full line
        run_xfer(32'h100, 48, 1, 1, 0, 0);      // three whole lines
        run_xfer(32'h305, 11, 0, 1, 0, 0);      // R3 fits exactly to line end
        run_xfer(32'h305, 12, 1, 1, 0, 0);      // R3 one byte over
        run_xfer(32'h40F, 1, 1, 0, 0, 0);       // last lane
        run_xfer(32'h40F, 40, 0, 1, 0, 0);      // R4 tail chunks
        run_xfer(32'h503, 40, 1, 1, 1, 0);      // R2 refusal and retry
        run_xfer(32'h607, 20, 0, 0, 0, 1);      // R9 drain while busy
        // R9 drain while idle
        drain_req = 1; @(negedge clk); drain_req = 0;
        chk(drain_done == 1 && drained == 1, "R9", "idle drain answer", int'(drain_done), 1);
        @(negedge clk);
        chk(drain_done == 0, "R9", "idle drain one cycle", int'(drain_done), 0);
        for (int t = 0; t < 60; t++)
            run_xfer(32'h1000 + int'($urandom % 1024), int'($urandom % 70), 1'($urandom),
                     1'($urandom), ($urandom % 5) == 0, ($urandom % 6) == 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule